// File: doc/BRIEF.md
# Four-Channel Fault Latch and Diagnosis Encoder

This block sits between the digitized fault detectors of a four-channel low-side driver and its serial diagnosis path. For each channel it receives three raw indications (current limit or overtemperature, open load, short to ground). It resolves them into one 2-bit code, requires that code to stay unchanged for a programmable number of clock cycles before accepting it, and then latches it until the host has read the diagnosis.

The latched codes are presented in two forms: an 8-bit word with two bits per channel, and a 4-bit summary with one pass/fail bit per channel. A common active-low fault flag goes low on the same clock edge that any channel latches a fault, so it can drive an interrupt line. A one-cycle clear pulse, produced by the serial logic when its select line is released, returns every latch to the normal code. The asynchronous reset is released synchronously inside the block.

Top module: `chan_fault_diag`

## Requirements
- R1: After reset every channel code is 11, the 8-bit word is 8'hFF, the summary is 4'b1111 and the fault flag is high.
- R2: Codes are 11 normal, 10 overload/short to supply/overtemperature, 01 open load, 00 short to ground; channel index k (0..3) occupies word bits [2k+1:2k].
- R3: When several raw indications of one channel are active together, short to ground wins over overload, and overload wins over open load.
- R4: A resolved non-normal code is latched on the DLY_CYC+1-th rising edge at which it is sampled unchanged; after only DLY_CYC such edges the latch still reads 11.
- R5: The persistence count restarts when the resolved code changes or the indication goes away, so an interrupted or switching indication needs a fresh full window.
- R6: A latched code is held after its raw indication disappears, until a clear.
- R7: A different fault that qualifies later on the same channel replaces the stored code.
- R8: A clear pulse returns every code to 11; an indication that is still present re-latches on the DLY_CYC-th edge after the clear edge.
- R9: If a clear and a newly qualifying fault fall on the same edge, the new fault is stored.
- R10: Summary bit k is 1 exactly when channel k holds 11.
- R11: The fault flag is low exactly while some channel holds a non-normal code, changing on the same edge as the latch.
- R12: Channels are independent: activity on one channel leaves the other codes at their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| ovld_raw_i | input | 4 | Per-channel current limit / overtemperature indication |
| open_raw_i | input | 4 | Per-channel open-load indication |
| sgnd_raw_i | input | 4 | Per-channel short-to-ground indication |
| clr_i | input | 1 | One-cycle clear pulse from select release |
| diag_word_o | output | 8 | Two-bit latched code per channel |
| diag_sum_o | output | 4 | One bit per channel, 1 = no fault |
| fault_no | output | 1 | Common fault flag, low while any fault is latched |

## Verification
The hardest situation to reach is a clear landing on exactly the edge at which a fault finishes its persistence window, since it needs the raw indication to be held for a precise count of edges and the clear raised on the last one. The bench gets there by holding an indication for DLY_CYC edges from a known idle state and raising the clear for the next edge. The restart of the window is reached the same way, by breaking or switching the indication one edge before it would qualify and counting a fresh window from there.

// File: rtl/chan_fault_pkg.sv
package chan_fault_pkg;

  typedef enum logic [1:0] {
    CODE_SGND = 2'b00,
    CODE_OPEN = 2'b01,
    CODE_OVLD = 2'b10,
    CODE_OK   = 2'b11
  } fcode_e;

  localparam int unsigned CODE_W = 2;

  // Resolve the raw indications of one channel; short to ground dominates.
  function automatic fcode_e resolve_code(input logic ovld, input logic open_ld,
                                          input logic sgnd);
    fcode_e r;
    if (sgnd)         r = CODE_SGND;
    else if (ovld)    r = CODE_OVLD;
    else if (open_ld) r = CODE_OPEN;
    else              r = CODE_OK;
    return r;
  endfunction

endpackage

// File: rtl/cfd_rst_sync.sv
module cfd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/cfd_channel.sv
module cfd_channel
  import chan_fault_pkg::*;
#(
  parameter int unsigned DLY_CYC = 50
) (
  input  logic   clk,
  input  logic   rst_ni,
  input  logic   ovld_i,
  input  logic   open_i,
  input  logic   sgnd_i,
  input  logic   clr_i,
  output fcode_e code_o
);

  localparam int unsigned CNT_W = $clog2(DLY_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LIM  = CNT_W'(DLY_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DLY_CYC - 1);

  fcode_e           raw_code;
  fcode_e           cand_q, cand_d;
  logic [CNT_W-1:0] cnt_q,  cnt_d;
  fcode_e           code_q, code_d;
  logic             same;
  logic             qual;
  logic             cand_en, cnt_en, code_en;

  always_comb begin
    raw_code = resolve_code(ovld_i, open_i, sgnd_i);
    same     = (raw_code == cand_q);
    qual     = same && (cand_q != CODE_OK) && (cnt_q == CNT_LAST);
  end

  // Candidate tracking and persistence counter (R4, R5, R8)
  always_comb begin
    cand_d  = cand_q;
    cand_en = !same;
    if (cand_en) cand_d = raw_code;

    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!same || cand_q == CODE_OK) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (qual) begin
      cnt_en = 1'b1;
      cnt_d  = CNT_LIM;
    end else if (clr_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (cnt_q != CNT_LIM) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  // Latch: a qualifying fault beats a clear on the same edge (R9)
  always_comb begin
    code_d  = code_q;
    code_en = qual || clr_i;
    if (qual)       code_d = cand_q;
    else if (clr_i) code_d = CODE_OK;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q <= CODE_OK;
      cnt_q  <= '0;
      code_q <= CODE_OK;
    end else begin
      if (cand_en) cand_q <= cand_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (code_en) code_q <= code_d;
    end
  end

  assign code_o = code_q;

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= CNT_LIM)
    else $error("a_r4_cnt_bound");

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (code_q != $past(code_q)) |-> ($past(qual) || $past(clr_i)))
    else $error("a_r6_hold");

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_i && !qual) |=> (code_q == CODE_OK))
    else $error("a_r8_clear");

  a_r9_clear_loses: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_i && qual) |=> (code_q != CODE_OK))
    else $error("a_r9_clear_loses");

endmodule

// File: rtl/cfd_format.sv
module cfd_format
  import chan_fault_pkg::*;
#(
  parameter int unsigned N_CH = 4
) (
  input  logic [N_CH*CODE_W-1:0] codes_i,
  output logic [N_CH*CODE_W-1:0] word_o,
  output logic [N_CH-1:0]        sum_o,
  output logic                   fault_no
);

  genvar k;
  generate
    for (k = 0; k < N_CH; k++) begin : g_ch
      assign word_o[k*CODE_W +: CODE_W] = codes_i[k*CODE_W +: CODE_W];
      assign sum_o[k] = &codes_i[k*CODE_W +: CODE_W];
    end
  endgenerate

  assign fault_no = &sum_o;

endmodule

// File: rtl/chan_fault_diag.sv
module chan_fault_diag
  import chan_fault_pkg::*;
#(
  parameter int unsigned N_CH    = 4,
  parameter int unsigned DLY_CYC = 50
) (
  input  logic                   clk,
  input  logic                   rst_ni,
  input  logic [N_CH-1:0]        ovld_raw_i,
  input  logic [N_CH-1:0]        open_raw_i,
  input  logic [N_CH-1:0]        sgnd_raw_i,
  input  logic                   clr_i,
  output logic [N_CH*CODE_W-1:0] diag_word_o,
  output logic [N_CH-1:0]        diag_sum_o,
  output logic                   fault_no
);

  localparam int unsigned WORD_W = N_CH * CODE_W;

  logic              rst_sn;
  logic [WORD_W-1:0] codes;

  cfd_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_sn)
  );

  genvar k;
  generate
    for (k = 0; k < N_CH; k++) begin : g_chan
      fcode_e c;
      cfd_channel #(.DLY_CYC(DLY_CYC)) u_ch (
        .clk    (clk),
        .rst_ni (rst_sn),
        .ovld_i (ovld_raw_i[k]),
        .open_i (open_raw_i[k]),
        .sgnd_i (sgnd_raw_i[k]),
        .clr_i  (clr_i),
        .code_o (c)
      );
      assign codes[k*CODE_W +: CODE_W] = c;
    end
  endgenerate

  cfd_format #(.N_CH(N_CH)) u_fmt (
    .codes_i  (codes),
    .word_o   (diag_word_o),
    .sum_o    (diag_sum_o),
    .fault_no (fault_no)
  );

  a_r11_flag_idle: assert property (@(posedge clk) disable iff (!rst_sn)
    (diag_word_o == {WORD_W{1'b1}}) |-> fault_no)
    else $error("a_r11_flag_idle");

  a_r11_flag_fall: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(fault_no) |-> (diag_sum_o != {N_CH{1'b1}}))
    else $error("a_r11_flag_fall");

  a_r10_sum_word: assert property (@(posedge clk) disable iff (!rst_sn)
    diag_sum_o[0] |-> (diag_word_o[1:0] == 2'b11))
    else $error("a_r10_sum_word");

endmodule

// File: tb/sim_chan_fault_diag.sv
`timescale 1ns/1ps
module sim_chan_fault_diag;

  localparam int DLY = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] ovld, opn, sgnd;
  logic       clr;
  logic [7:0] word;
  logic [3:0] sumb;
  logic       fault_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  chan_fault_diag #(.N_CH(4), .DLY_CYC(DLY)) u0 (
    .clk         (clk),
    .rst_ni      (rst_n),
    .ovld_raw_i  (ovld),
    .open_raw_i  (opn),
    .sgnd_raw_i  (sgnd),
    .clr_i       (clr),
    .diag_word_o (word),
    .diag_sum_o  (sumb),
    .fault_no    (fault_n)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_code(input logic o, input logic p, input logic s);
    if (s)      return 2'b00;
    else if (o) return 2'b10;
    else if (p) return 2'b01;
    return 2'b11;
  endfunction

  function automatic logic [7:0] word_with(input int ch, input logic [1:0] c);
    logic [7:0] w;
    w = 8'hFF;
    w[2*ch +: 2] = c;
    return w;
  endfunction

  function automatic logic [3:0] sum_of(input logic [7:0] w);
    logic [3:0] s;
    for (int i = 0; i < 4; i++) s[i] = &w[2*i +: 2];
    return s;
  endfunction

  task automatic idle_raw();
    ovld = '0; opn = '0; sgnd = '0;
  endtask

  task automatic pulse_clr();
    clr = 1'b1; tick(); clr = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; idle_raw();
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    // R1 reset state
    chk("R1 word", word, 8'hFF);
    chk("R1 sum", sumb, 4'hF);
    chk("R1 flag", fault_n, 1);

    // Sweep: every channel, every combination of raw indications
    for (int ch = 0; ch < 4; ch++) begin
      for (int c = 1; c < 8; c++) begin
        logic [1:0] ec;
        logic [7:0] ew;
        ec = exp_code(c[0], c[1], c[2]);
        ew = word_with(ch, ec);
        ovld[ch] = c[0]; opn[ch] = c[1]; sgnd[ch] = c[2];
        repeat (DLY) tick();
        chk("R4 not yet latched", word, 8'hFF);
        tick();
        chk("R2/R3/R12 latched word", word, ew);
        chk("R10 summary", sumb, sum_of(ew));
        chk("R11 flag low", fault_n, 0);
        idle_raw(); tick();
        chk("R6 held after removal", word, ew);
        pulse_clr();
        chk("R8 cleared", word, 8'hFF);
        chk("R11 flag high", fault_n, 1);
      end
    end

    // R5: interrupted indication restarts the window
    ovld[1] = 1'b1; repeat (DLY) tick();
    ovld[1] = 1'b0; tick();
    ovld[1] = 1'b1; repeat (DLY) tick();
    chk("R5 gap restarts", word, 8'hFF);
    tick();
    chk("R5 latched after full window", word, word_with(1, 2'b10));
    idle_raw(); tick(); pulse_clr();

    // R5: switching fault type restarts the window
    ovld[2] = 1'b1; repeat (DLY) tick();
    ovld[2] = 1'b0; opn[2] = 1'b1; repeat (DLY) tick();
    chk("R5 switch restarts", word, 8'hFF);
    tick();
    chk("R5 switched code", word, word_with(2, 2'b01));

    // R7: later different fault overwrites
    opn[2] = 1'b0; sgnd[2] = 1'b1; repeat (DLY) tick();
    chk("R7 old code kept during window", word, word_with(2, 2'b01));
    tick();
    chk("R7 overwritten", word, word_with(2, 2'b00));

    // R8: persisting indication re-latches DLY edges after clear
    pulse_clr();
    chk("R8 clear with fault present", word, 8'hFF);
    repeat (DLY - 1) tick();
    chk("R8 not yet relatched", word, 8'hFF);
    tick();
    chk("R8 relatched", word, word_with(2, 2'b00));
    idle_raw(); tick(); pulse_clr();

    // R9: clear and qualification on the same edge
    opn[3] = 1'b1; repeat (DLY) tick();
    pulse_clr();
    chk("R9 new fault kept over clear", word, word_with(3, 2'b01));
    chk("R11 flag after R9", fault_n, 0);

    // R12: two channels latch independently
    opn[3] = 1'b0; ovld[0] = 1'b1; repeat (DLY + 1) tick();
    chk("R12 two channels", word, 8'h7E);
    chk("R10 two channels", sumb, 4'b0110);
    idle_raw(); tick(); pulse_clr();
    chk("R8 final clear", word, 8'hFF);

    summary();
  end

endmodule